// File: doc/BRIEF.md
# Serial Message Link Host Interface

This block sits between a CPU register bus and a serial vehicle-network message engine. The CPU fills a transmit buffer and writes a byte count to start a frame. The block then waits until the line is idle and streams the data bytes to the engine. It appends a CRC byte that it computes itself. In the other direction, the engine delivers received bytes together with an end-of-message marker and an error indication. Error-free messages are kept in one of two receive slots. They stay there until the CPU releases them.

Two flags summarise the link for the CPU. Transmit-done is set only on a successful transmission. Receive-done is set while a received message is waiting. Each flag is cleared by touching its companion register, not the status register. A read or a write of the transmit-count register clears transmit-done. A read or a write of the receive-status register releases the oldest waiting message. Receive-done clears only when no other message is queued. An interrupt line combines both flags under an enable bit.

Address map (6-bit address, default depth of 11 bytes):
- Control register at 0: bits [1:0] rate select, bit 7 interrupt enable.
- Status register at 1: bit 0 transmit-done, bit 1 receive-done, bits [7:4] byte count of the current received message.
- Transmit-count register at 2.
- Receive-status register at 3: bits [3:0] byte count of the current received message.
- Transmit buffer at 0x10–0x1A.
- Receive buffer at 0x20–0x2A.

Top module: `msgl_host`

## Requirements
- R1: After reset, the control and status registers read 0x00, `irq` is low and `tx_valid` is low.
- R2: Writing a count N (1 to 11) to address 2 while the transmitter is idle sets up a frame. `tx_valid` is raised only once `line_idle` is high. The frame is N buffer bytes from address 0x10 upward, then one CRC byte, and `tx_last` is high only on the CRC byte. Each byte is held until `tx_take` accepts it. A read of address 2 returns the last accepted count.
- R3: The CRC byte uses the polynomial x^8+x^4+x^3+x^2+1 (0x1D). It is preset to 0xFF, shifted MSB first over the data bytes, and inverted before it is sent.
- R4: A count of 0 or above 11 is ignored. A count write is also ignored while a frame is waiting or in progress, and so is a transmit-buffer write.
- R5: Status bit 0 (transmit-done) is set one cycle after `eng_tx_done` is pulsed with `eng_tx_ok` high during a frame. A pulse with `eng_tx_ok` low leaves it clear. Any read or write of address 2 clears it.
- R6: An error-free message of 1 to 11 bytes ending with `rx_eom` sets status bit 1 (receive-done). Its byte count is reported in the receive-status register and in status bits [7:4].
- R7: A message ended with `rx_bad` high is dropped with no flag, count or buffer change. So is a message longer than 11 bytes, and so is a message that arrives while two messages are already waiting.
- R8: With two messages waiting, a read or write of address 3 releases the first. Receive-done and `irq` stay high, and the second message's count and bytes are presented next. Releasing the last waiting message clears receive-done.
- R9: `irq` is high exactly when control bit 7 is set and transmit-done or receive-done is set.
- R10: Received bytes read from 0x20 upward can be reread any number of times, in any order, until the message is released.
- R11: The control register reads back what was written to bits 7 and [1:0], and `rate_sel` follows bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 6 | Register and buffer address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rdata | output | 8 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |
| rate_sel | output | 2 | Rate select for the message engine |
| line_idle | input | 1 | Engine reports the line idle |
| tx_valid | output | 1 | A frame byte is offered |
| tx_data | output | 8 | Offered frame byte |
| tx_last | output | 1 | Offered byte is the CRC byte |
| tx_take | input | 1 | Engine accepts the offered byte |
| eng_tx_done | input | 1 | Engine ends the frame (pulse) |
| eng_tx_ok | input | 1 | Qualifies eng_tx_done as a success |
| rx_stb | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| rx_eom | input | 1 | End of received message (pulse, never with rx_stb) |
| rx_bad | input | 1 | Qualifies rx_eom as an errored message |

## Verification
Register reads are combinational, so read data is sampled one nanosecond after the address and strobe are driven on a falling edge. The read's side effect, such as a flag clear or a message release, lands on the next rising edge. It is checked by a later read. Flags and the interrupt change at the first rising edge after the `eng_tx_done` or `rx_eom` pulse, so the bench samples them at the falling edge that follows. `tx_data` moves to the next byte at the rising edge on which `tx_take` is high. The bench therefore captures each frame byte at the falling edge before it raises `tx_take`.

// File: rtl/msgl_pkg.sv
package msgl_pkg;

  typedef logic [7:0] byte_t;

  localparam byte_t CRC_POLY   = 8'h1D;
  localparam byte_t CRC_PRESET = 8'hFF;

  typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_SEND, TX_FIN} tx_st_e;

  // One byte through the CRC register, most significant bit first.
  function automatic byte_t crc_step(byte_t crc_in, byte_t din);
    byte_t c;
    logic  fb;
    c = crc_in;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ din[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/msgl_tx.sv
module msgl_tx
  import msgl_pkg::*;
#(
  parameter int unsigned DEPTH = 11,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] cpu_idx,
  input  logic          buf_we,
  input  byte_t         wdata,
  output byte_t         buf_q,
  input  logic          cnt_we,
  output logic [CW-1:0] cnt_q,
  input  logic          line_idle,
  input  logic          tx_take,
  input  logic          eng_done,
  input  logic          eng_ok,
  output logic          tx_valid,
  output byte_t         tx_data,
  output logic          tx_last,
  output logic          done_evt
);

  localparam byte_t         DEPTH_B = byte_t'(DEPTH);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  byte_t         mem [DEPTH];
  tx_st_e        st_q, st_d;
  logic [CW-1:0] cnt_d, idx_q, idx_d;
  byte_t         crc_q, crc_d, cur_byte;
  logic          busy, at_crc, cnt_ok;

  assign busy     = (st_q != TX_IDLE);
  assign at_crc   = (idx_q == cnt_q);
  assign cnt_ok   = (wdata != 8'd0) && (wdata <= DEPTH_B);
  assign cur_byte = (idx_q < DEPTH_C) ? mem[idx_q[IW-1:0]] : 8'h00;
  assign buf_q    = mem[cpu_idx];

  // Buffer storage, frozen while a frame is pending or in flight.
  always_ff @(posedge clk) begin
    if (buf_we && !busy) mem[cpu_idx] <= wdata;
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    crc_d = crc_q;
    unique case (st_q)
      TX_IDLE: if (cnt_we && cnt_ok) begin
        cnt_d = wdata[CW-1:0];
        st_d  = TX_WAIT;
      end
      TX_WAIT: if (line_idle) begin
        st_d  = TX_SEND;
        idx_d = '0;
        crc_d = CRC_PRESET;
      end
      TX_SEND: begin
        if (eng_done)        st_d = TX_IDLE;
        else if (tx_take) begin
          if (at_crc)        st_d = TX_FIN;
          else begin
            crc_d = crc_step(crc_q, cur_byte);
            idx_d = idx_q + CW'(1);
          end
        end
      end
      TX_FIN: if (eng_done) st_d = TX_IDLE;
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      crc_q <= CRC_PRESET;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      crc_q <= crc_d;
    end
  end

  assign tx_valid = (st_q == TX_SEND);
  assign tx_last  = tx_valid && at_crc;
  assign tx_data  = at_crc ? ~crc_q : cur_byte;
  assign done_evt = eng_done && eng_ok && ((st_q == TX_SEND) || (st_q == TX_FIN));

endmodule

// File: rtl/msgl_rx.sv
module msgl_rx
  import msgl_pkg::*;
#(
  parameter int unsigned DEPTH = 11,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_stb,
  input  byte_t         rx_byte,
  input  logic          rx_eom,
  input  logic          rx_bad,
  input  logic          release_i,
  input  logic [IW-1:0] rd_idx,
  output byte_t         rd_data,
  output logic [CW-1:0] head_len,
  output logic [1:0]    pend
);

  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  byte_t         mem [2][DEPTH];
  logic [CW-1:0] len_q [2];
  logic          head_q, head_d, wr_slot, full, wr_en, push, pop;
  logic          drop_q, drop_d;
  logic [1:0]    pend_q, pend_d;
  logic [CW-1:0] asm_q, asm_d;

  assign full    = (pend_q == 2'd2);
  assign wr_slot = head_q ^ (pend_q != 2'd0);
  assign wr_en   = rx_stb && !full && !drop_q && (asm_q < DEPTH_C);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_slot][asm_q[IW-1:0]] <= rx_byte;
  end

  always_comb begin
    asm_d  = asm_q;
    drop_d = drop_q;
    push   = 1'b0;
    if (rx_stb) begin
      if (wr_en) asm_d  = asm_q + CW'(1);
      else       drop_d = 1'b1;
    end
    if (rx_eom) begin
      push   = !rx_bad && !drop_q && !full && (asm_q != '0);
      asm_d  = '0;
      drop_d = 1'b0;
    end
    pop    = release_i && (pend_q != 2'd0);
    pend_d = pend_q + {1'b0, push} - {1'b0, pop};
    head_d = pop ? ~head_q : head_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= 1'b0;
      pend_q <= 2'd0;
      asm_q  <= '0;
      drop_q <= 1'b0;
      for (int s = 0; s < 2; s++) len_q[s] <= '0;
    end else begin
      head_q <= head_d;
      pend_q <= pend_d;
      asm_q  <= asm_d;
      drop_q <= drop_d;
      if (push) len_q[wr_slot] <= asm_q;
    end
  end

  assign pend     = pend_q;
  assign head_len = (pend_q != 2'd0) ? len_q[head_q] : '0;
  assign rd_data  = mem[head_q][rd_idx];

endmodule

// File: rtl/msgl_host.sv
module msgl_host
  import msgl_pkg::*;
#(
  parameter int unsigned DEPTH  = 11,
  parameter int unsigned RATE_W = 2,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned AW = IW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [7:0]        cpu_rdata,
  output logic              irq,
  output logic [RATE_W-1:0] rate_sel,
  input  logic              line_idle,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_take,
  input  logic              eng_tx_done,
  input  logic              eng_tx_ok,
  input  logic              rx_stb,
  input  logic [7:0]        rx_byte,
  input  logic              rx_eom,
  input  logic              rx_bad
);

  localparam logic [AW-1:0] A_CTRL   = AW'(0);
  localparam logic [AW-1:0] A_STAT   = AW'(1);
  localparam logic [AW-1:0] A_TXCNT  = AW'(2);
  localparam logic [AW-1:0] A_RXSTAT = AW'(3);
  localparam logic [1:0]    PG_TX    = 2'd1;
  localparam logic [1:0]    PG_RX    = 2'd2;
  localparam logic [IW:0]   DEPTH_X  = (IW + 1)'(DEPTH);

  // Reset: asserted at once, released through two flops.
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  // Address decode.
  logic          acc, in_buf, hit_txb, hit_rxb, hit_txcnt, hit_rxstat, ctrl_we;
  logic [IW-1:0] bidx;
  assign acc        = cpu_rd || cpu_wr;
  assign bidx       = cpu_addr[IW-1:0];
  assign in_buf     = ({1'b0, bidx} < DEPTH_X);
  assign hit_txb    = (cpu_addr[AW-1:IW] == PG_TX) && in_buf;
  assign hit_rxb    = (cpu_addr[AW-1:IW] == PG_RX) && in_buf;
  assign hit_txcnt  = (cpu_addr == A_TXCNT);
  assign hit_rxstat = (cpu_addr == A_RXSTAT);
  assign ctrl_we    = cpu_wr && (cpu_addr == A_CTRL);

  // Control register.
  logic              ie_q, ie_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  always_comb begin
    ie_d   = ie_q;
    rate_d = rate_q;
    if (ctrl_we) begin
      ie_d   = cpu_wdata[7];
      rate_d = cpu_wdata[RATE_W-1:0];
    end
  end

  // Transmit-done flag: a success sets it, an access to the count register clears it.
  logic tx_done_q, tx_done_d, done_evt;
  always_comb begin
    tx_done_d = tx_done_q;
    if (done_evt)              tx_done_d = 1'b1;
    else if (acc && hit_txcnt) tx_done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ie_q      <= 1'b0;
      rate_q    <= '0;
      tx_done_q <= 1'b0;
    end else begin
      ie_q      <= ie_d;
      rate_q    <= rate_d;
      tx_done_q <= tx_done_d;
    end
  end

  byte_t         txb_q, rxb_q;
  logic [CW-1:0] tx_cnt, head_len;
  logic [1:0]    rx_pend;
  logic          rx_done;

  msgl_tx #(.DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst_n(srst_n),
    .cpu_idx(bidx), .buf_we(cpu_wr && hit_txb), .wdata(cpu_wdata), .buf_q(txb_q),
    .cnt_we(cpu_wr && hit_txcnt), .cnt_q(tx_cnt),
    .line_idle(line_idle), .tx_take(tx_take), .eng_done(eng_tx_done), .eng_ok(eng_tx_ok),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .done_evt(done_evt)
  );

  msgl_rx #(.DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(srst_n),
    .rx_stb(rx_stb), .rx_byte(rx_byte), .rx_eom(rx_eom), .rx_bad(rx_bad),
    .release_i(acc && hit_rxstat), .rd_idx(bidx), .rd_data(rxb_q),
    .head_len(head_len), .pend(rx_pend)
  );

  assign rx_done  = (rx_pend != 2'd0);
  assign irq      = ie_q && (tx_done_q || rx_done);
  assign rate_sel = rate_q;

  always_comb begin
    cpu_rdata = 8'h00;
    if (cpu_addr == A_CTRL)   cpu_rdata = {ie_q, 7'(rate_q)};
    else if (cpu_addr == A_STAT)
      cpu_rdata = (8'(head_len) << 4) | {6'b0, rx_done, tx_done_q};
    else if (hit_txcnt)       cpu_rdata = 8'(tx_cnt);
    else if (hit_rxstat)      cpu_rdata = 8'(head_len);
    else if (hit_txb)         cpu_rdata = txb_q;
    else if (hit_rxb)         cpu_rdata = rxb_q;
  end

endmodule

// File: rtl/msgl_host_chk.sv
module msgl_host_chk #(
  parameter int unsigned AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_rd,
  input logic          cpu_wr,
  input logic          irq,
  input logic          ie_q,
  input logic          tx_valid,
  input logic          tx_last,
  input logic [7:0]    tx_data,
  input logic          tx_take,
  input logic          eng_tx_done,
  input logic          eng_tx_ok,
  input logic          tx_done_q,
  input logic [1:0]    rx_pend,
  input logic          rx_eom,
  input logic          rx_bad
);

  logic txcnt_acc, rxstat_acc;
  assign txcnt_acc  = (cpu_rd || cpu_wr) && (cpu_addr == AW'(2));
  assign rxstat_acc = (cpu_rd || cpu_wr) && (cpu_addr == AW'(3));

  // R2: the CRC marker only accompanies an offered byte
  p_last_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  // R2: an offered byte is held until the engine takes it
  p_hold_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_take && !eng_tx_done) |=> (tx_valid && $stable(tx_data)));

  // R5: the flag rises only after a successful end of frame
  p_done_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done_q) |-> $past(eng_tx_done && eng_tx_ok));

  // R5: an access to the count register clears the flag
  p_done_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (txcnt_acc && !eng_tx_done) |=> !tx_done_q);

  // R7: an errored end of message never adds a waiting message
  p_bad_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eom && rx_bad && !rxstat_acc) |=> (rx_pend == $past(rx_pend)));

  // R8: at most two messages wait
  p_pend_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pend != 2'd3);

  // R9: no interrupt while disabled
  p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> !irq);

endmodule

bind msgl_host msgl_host_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .irq(irq), .ie_q(ie_q), .tx_valid(tx_valid), .tx_last(tx_last), .tx_data(tx_data),
  .tx_take(tx_take), .eng_tx_done(eng_tx_done), .eng_tx_ok(eng_tx_ok),
  .tx_done_q(tx_done_q), .rx_pend(rx_pend), .rx_eom(rx_eom), .rx_bad(rx_bad)
);

// File: tb/tb_msgl_host.sv
`timescale 1ns/1ps
module tb_msgl_host;

  logic       clk, rst_n;
  logic [5:0] cpu_addr;
  logic [7:0] cpu_wdata, cpu_rdata, tx_data, rx_byte;
  logic       cpu_rd, cpu_wr, irq, line_idle, tx_valid, tx_last, tx_take;
  logic       eng_tx_done, eng_tx_ok, rx_stb, rx_eom, rx_bad;
  logic [1:0] rate_sel;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0] txb [16];
  logic [7:0] frm [16];
  logic       lst [16];
  logic [7:0] msg [16];
  int         flen;
  logic [7:0] rv;

  msgl_host dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .irq(irq),
    .rate_sel(rate_sel), .line_idle(line_idle), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_take(tx_take),
    .eng_tx_done(eng_tx_done), .eng_tx_ok(eng_tx_ok), .rx_stb(rx_stb),
    .rx_byte(rx_byte), .rx_eom(rx_eom), .rx_bad(rx_bad)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input int n);
    logic [7:0] c = 8'hFF;
    for (int k = 0; k < n; k++)
      for (int b = 7; b >= 0; b--) begin
        if (c[7] ^ txb[k][b]) c = {c[6:0], 1'b0} ^ 8'h1D;
        else                  c = {c[6:0], 1'b0};
      end
    return ~c;
  endfunction

  task automatic cpu_wr_t(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic cpu_rd_t(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_rd = 1'b1;
    #1 d = cpu_rdata;
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  task automatic collect_frame();
    flen = 0;
    while (flen < 16) begin
      int w = 0;
      while (!tx_valid && w < 50) begin @(negedge clk); w++; end
      if (!tx_valid) break;
      frm[flen] = tx_data; lst[flen] = tx_last; flen++;
      tx_take = 1'b1; @(negedge clk); tx_take = 1'b0;
      if (lst[flen-1]) break;
    end
  endtask

  task automatic end_frame(input logic ok);
    @(negedge clk); eng_tx_done = 1'b1; eng_tx_ok = ok;
    @(negedge clk); eng_tx_done = 1'b0; eng_tx_ok = 1'b0;
  endtask

  task automatic rx_send(input int n, input logic bad);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); rx_stb = 1'b1; rx_byte = msg[k];
    end
    @(negedge clk); rx_stb = 1'b0; rx_eom = 1'b1; rx_bad = bad;
    @(negedge clk); rx_eom = 1'b0; rx_bad = 1'b0;
  endtask

  task automatic t_reset();
    cpu_rd_t(6'h00, rv); chk("R1 ctrl", rv, 8'h00);
    cpu_rd_t(6'h01, rv); chk("R1 status", rv, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 tx_valid", tx_valid, 1'b0);
  endtask

  task automatic t_ctrl();
    cpu_wr_t(6'h00, 8'h81);
    cpu_rd_t(6'h00, rv); chk("R11 ctrl readback", rv, 8'h81);
    chk("R11 rate_sel", rate_sel, 2'd1);
  endtask

  task automatic t_tx_basic();
    txb[0] = 8'h5A; txb[1] = 8'h6B; txb[2] = 8'h7C;
    for (int k = 0; k < 3; k++) cpu_wr_t(6'h10 + 6'(k), txb[k]);
    line_idle = 1'b0;
    cpu_wr_t(6'h02, 8'd3);
    repeat (5) @(negedge clk);
    chk("R2 waits for idle line", tx_valid, 1'b0);
    line_idle = 1'b1;
    collect_frame();
    line_idle = 1'b0;
    chk("R2 frame length", flen, 4);
    for (int k = 0; k < 3; k++) chk("R2 data byte", frm[k], txb[k]);
    chk("R3 crc byte", frm[3], ref_crc(3));
    chk("R2 last on crc", lst[3], 1'b1);
    chk("R2 not last on data", lst[2], 1'b0);
    cpu_rd_t(6'h01, rv); chk("R5 no flag before done", rv[0], 1'b0);
    end_frame(1'b1);
    cpu_rd_t(6'h01, rv); chk("R5 flag after success", rv, 8'h01);
    chk("R9 irq on tx done", irq, 1'b1);
    cpu_rd_t(6'h02, rv); chk("R2 count readback", rv, 8'd3);
    cpu_rd_t(6'h01, rv); chk("R5 read clears flag", rv, 8'h00);
    chk("R9 irq clears", irq, 1'b0);
  endtask

  task automatic t_tx_ignore();
    line_idle = 1'b1;
    cpu_wr_t(6'h02, 8'd0);
    repeat (4) @(negedge clk);
    chk("R4 count zero ignored", tx_valid, 1'b0);
    cpu_wr_t(6'h02, 8'd12);
    repeat (4) @(negedge clk);
    chk("R4 count twelve ignored", tx_valid, 1'b0);
    cpu_rd_t(6'h02, rv); chk("R4 count kept", rv, 8'd3);
    line_idle = 1'b0;
    cpu_wr_t(6'h02, 8'd2);
    cpu_wr_t(6'h02, 8'd5);
    cpu_wr_t(6'h10, 8'hEE);
    line_idle = 1'b1;
    collect_frame();
    line_idle = 1'b0;
    chk("R4 busy count ignored", flen, 3);
    chk("R4 busy buffer write ignored", frm[0], 8'h5A);
    chk("R3 crc two bytes", frm[2], ref_crc(2));
    end_frame(1'b0);
    cpu_rd_t(6'h01, rv); chk("R5 failure leaves flag clear", rv[0], 1'b0);
  endtask

  task automatic t_tx_max();
    for (int k = 0; k < 11; k++) begin
      txb[k] = 8'(k * 8'h17 + 3);
      cpu_wr_t(6'h10 + 6'(k), txb[k]);
    end
    cpu_rd_t(6'h1A, rv); chk("R2 buffer readback", rv, txb[10]);
    cpu_wr_t(6'h02, 8'd11);
    line_idle = 1'b1;
    collect_frame();
    line_idle = 1'b0;
    chk("R2 max frame length", flen, 12);
    chk("R2 max last data", frm[10], txb[10]);
    chk("R3 crc eleven bytes", frm[11], ref_crc(11));
    end_frame(1'b1);
    cpu_rd_t(6'h01, rv); chk("R5 flag set", rv[0], 1'b1);
    cpu_wr_t(6'h02, 8'd0);
    cpu_rd_t(6'h01, rv); chk("R5 write clears flag", rv[0], 1'b0);
  endtask

  task automatic t_rx_basic();
    msg[0] = 8'h10; msg[1] = 8'h21; msg[2] = 8'h32; msg[3] = 8'h43;
    rx_send(4, 1'b0);
    cpu_rd_t(6'h01, rv); chk("R6 status count and flag", rv, 8'h42);
    chk("R9 irq on rx", irq, 1'b1);
    for (int p = 0; p < 2; p++) begin
      cpu_rd_t(6'h23, rv); chk("R10 byte 3", rv, 8'h43);
      cpu_rd_t(6'h21, rv); chk("R10 byte 1", rv, 8'h21);
      cpu_rd_t(6'h20, rv); chk("R10 byte 0", rv, 8'h10);
      cpu_rd_t(6'h22, rv); chk("R10 byte 2", rv, 8'h32);
    end
    cpu_rd_t(6'h03, rv); chk("R6 rx status count", rv, 8'd4);
    cpu_rd_t(6'h01, rv); chk("R6 release clears flag", rv, 8'h00);
    chk("R9 irq clears on release", irq, 1'b0);
  endtask

  task automatic t_rx_discard();
    msg[0] = 8'hAA; msg[1] = 8'hBB; msg[2] = 8'hCC;
    rx_send(3, 1'b1);
    cpu_rd_t(6'h01, rv); chk("R7 bad message dropped", rv, 8'h00);
    for (int k = 0; k < 12; k++) msg[k] = 8'(k);
    rx_send(12, 1'b0);
    cpu_rd_t(6'h01, rv); chk("R7 overlong dropped", rv, 8'h00);
    chk("R7 no irq", irq, 1'b0);
  endtask

  task automatic t_rx_queue();
    msg[0] = 8'h11; msg[1] = 8'h22; rx_send(2, 1'b0);
    msg[0] = 8'hA1; msg[1] = 8'hA2; msg[2] = 8'hA3; rx_send(3, 1'b0);
    cpu_rd_t(6'h01, rv); chk("R8 first presented", rv, 8'h22);
    cpu_rd_t(6'h20, rv); chk("R10 first byte", rv, 8'h11);
    cpu_rd_t(6'h03, rv); chk("R8 first count", rv, 8'd2);
    cpu_rd_t(6'h01, rv); chk("R8 flag stays, second next", rv, 8'h32);
    chk("R8 irq stays", irq, 1'b1);
    cpu_rd_t(6'h20, rv); chk("R8 second byte 0", rv, 8'hA1);
    cpu_wr_t(6'h03, 8'h00);
    cpu_rd_t(6'h01, rv); chk("R8 last release clears", rv, 8'h00);
    msg[0] = 8'h01; rx_send(1, 1'b0);
    msg[0] = 8'h02; rx_send(1, 1'b0);
    msg[0] = 8'h03; rx_send(1, 1'b0);
    cpu_rd_t(6'h03, rv);
    cpu_rd_t(6'h20, rv); chk("R8 second of three", rv, 8'h02);
    cpu_rd_t(6'h03, rv);
    cpu_rd_t(6'h01, rv); chk("R7 third while full dropped", rv, 8'h00);
  endtask

  task automatic t_irq_mask();
    cpu_wr_t(6'h00, 8'h02);
    chk("R11 rate_sel update", rate_sel, 2'd2);
    msg[0] = 8'h77; rx_send(1, 1'b0);
    cpu_rd_t(6'h01, rv); chk("R6 one-byte message", rv, 8'h12);
    chk("R9 irq masked", irq, 1'b0);
    cpu_rd_t(6'h03, rv);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_rd = 1'b0; cpu_wr = 1'b0;
    line_idle = 1'b0; tx_take = 1'b0; eng_tx_done = 1'b0; eng_tx_ok = 1'b0;
    rx_stb = 1'b0; rx_byte = '0; rx_eom = 1'b0; rx_bad = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ctrl();
    t_tx_basic();
    t_tx_ignore();
    t_tx_max();
    t_rx_basic();
    t_rx_discard();
    t_rx_queue();
    t_irq_mask();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      summary();
      $finish;
    end
  end

endmodule